// File: doc/BRIEF.md
# Masked Pipelined Equality Comparator

This block raises a single match flag when an input data word agrees with a reference pattern on every bit position that a mask leaves in play. A mask bit of 1 takes its position out of the comparison. A mask bit of 0 requires the data bit and the pattern bit to be equal. The block has one dynamic input bus next to the data bus. A build-time choice decides what that bus supplies: the pattern, with a fixed mask taken from a parameter, or the mask, with a fixed pattern taken from a parameter. In a third setting both come from parameters and the bus is not used.

The comparison result goes through a chain of zero to three register stages, fixed at build time. Latency zero gives a purely combinational flag. The stages advance only while the active-high clock enable is asserted. An active-high synchronous reset clears every stage, whatever the state of the enable.

Elaboration rejects a data width outside 1 to 48, a latency outside 0 to 3, and a configuration that asks the dynamic bus to supply both the pattern and the mask.

Top module: `masked_eq_cmp`

## Requirements
- R1: Only the low `WIDTH` bits (1 to 48) of the data, of the bus and of the static pattern and mask parameters take part in the comparison. Parameter bits above `WIDTH` have no effect on the flag.
- R2: A mask bit of 1 removes its position from the comparison. A mask bit of 0 requires the data bit to equal the pattern bit. The flag is 1 exactly when every unmasked position agrees.
- R3: With the pattern source set to the bus (`PAT_SRC = SRC_BUS`), the bus value is the pattern and `STATIC_MSK` is the mask. With both sources static, the bus has no effect on the flag.
- R4: With the mask source set to the bus (`MSK_SRC = SRC_BUS`), the bus value is the mask and `STATIC_PAT` is the pattern.
- R5: With `LATENCY` = L, L from 1 to 3, `match_q` shows the comparison of the inputs that were present at the L-th most recent rising edge with `ce` high and `rst` low. With L = 0, `match_q` follows the current inputs combinationally.
- R6: While `ce` is low and `rst` is low, every pipeline stage holds its value, so `match_q` stays constant for L ≥ 1.
- R7: A rising edge with `rst` high clears every stage even when `ce` is low, so `match_q` reads 0 after that edge for L ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, takes priority over `ce` |
| ce | input | 1 | Clock enable for the pipeline stages, active high |
| data_in | input | WIDTH | Word under test |
| dyn_bus | input | WIDTH | Dynamic pattern or dynamic mask, depending on the build-time selection |
| match_q | output | 1 | Match flag, active high, delayed by `LATENCY` enabled cycles |

## Verification
The bench builds four copies of the block, one for each latency from 0 to 3. Between them they cover the bus used as pattern, the bus used as mask, and both sources static. It drives data that differs from the pattern only in masked positions, and a design that inverted the mask sense or ignored the mask would drop the flag there. It also sets random upper bits above a narrow width, and a design that compared parameter bits outside `WIDTH` would miss those matches. Stretches of low `ce` catch a pipeline that shifts without the enable or that counts idle cycles as latency. A reset applied with `ce` low catches a design that gates its reset with the enable.

// File: rtl/meq_pkg.sv
package meq_pkg;

   // Largest supported word; static parameters are always this wide.
   localparam int MEQ_MAX_W   = 48;
   localparam int MEQ_MAX_LAT = 3;

   // Where the pattern or the mask comes from.
   typedef enum logic {
      SRC_STATIC = 1'b0,
      SRC_BUS    = 1'b1
   } meq_src_e;

endpackage

// File: rtl/meq_operand_sel.sv
module meq_operand_sel
   import meq_pkg::*;
#(
   parameter int                     WIDTH      = 48,
   parameter meq_src_e               PAT_SRC    = SRC_BUS,
   parameter meq_src_e               MSK_SRC    = SRC_STATIC,
   parameter logic [MEQ_MAX_W-1:0]   STATIC_PAT = '0,
   parameter logic [MEQ_MAX_W-1:0]   STATIC_MSK = '0
) (
   input  logic [WIDTH-1:0] dyn_bus,
   output logic [WIDTH-1:0] pat,
   output logic [WIDTH-1:0] msk
);

   // R1: only the low WIDTH bits of each static parameter are used
   localparam logic [WIDTH-1:0] PAT_LO = STATIC_PAT[WIDTH-1:0];
   localparam logic [WIDTH-1:0] MSK_LO = STATIC_MSK[WIDTH-1:0];

   generate
      if (PAT_SRC == SRC_BUS && MSK_SRC == SRC_BUS) begin : g_bad_src
         $error("meq_operand_sel: bus cannot supply both pattern and mask");
      end

      if (PAT_SRC == SRC_BUS) begin : g_pat_bus
         assign pat = dyn_bus;
      end else begin : g_pat_static
         assign pat = PAT_LO;
      end

      if (MSK_SRC == SRC_BUS) begin : g_msk_bus
         assign msk = dyn_bus;
      end else begin : g_msk_static
         assign msk = MSK_LO;
      end

      if (PAT_SRC == SRC_STATIC && MSK_SRC == SRC_STATIC) begin : g_bus_idle
         logic unused_bus;
         assign unused_bus = ^dyn_bus;
      end
   endgenerate

endmodule

// File: rtl/meq_match_core.sv
module meq_match_core #(
   parameter int WIDTH = 48
) (
   input  logic [WIDTH-1:0] data,
   input  logic [WIDTH-1:0] pat,
   input  logic [WIDTH-1:0] msk,
   output logic             hit
);

   logic [WIDTH-1:0] agree;

   // One agreement bit per position: excluded by the mask, or equal.
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign agree[b] = msk[b] | ~(data[b] ^ pat[b]);
      end
   endgenerate

   assign hit = &agree;

   always_comb begin
      if (!$isunknown({data, pat, msk})) begin
         AST_FULL_MASK_HITS: assert (!(&msk) || hit)            // R2
            else $error("fully masked word did not match");
         AST_EQUAL_WORD_HITS: assert ((data != pat) || hit)     // R2
            else $error("identical words did not match");
      end
   end

endmodule

// File: rtl/meq_delay_line.sv
module meq_delay_line
   import meq_pkg::*;
#(
   parameter int LATENCY = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic d,
   output logic q
);

   generate
      if (LATENCY < 0 || LATENCY > MEQ_MAX_LAT) begin : g_bad_lat
         $error("meq_delay_line: LATENCY must lie in 0..3");
      end

      if (LATENCY == 0) begin : g_comb
         logic unused_ctl;
         assign unused_ctl = clk ^ rst ^ ce;
         assign q = d;
      end else begin : g_pipe
         logic [LATENCY-1:0] stg;

         for (genvar i = 0; i < LATENCY; i++) begin : g_stage
            logic nxt;
            if (i == 0) begin : g_head
               assign nxt = d;
            end else begin : g_tail
               assign nxt = stg[i-1];
            end

            // reset wins over the enable
            always_ff @(posedge clk) begin
               if (rst)     stg[i] <= 1'b0;
               else if (ce) stg[i] <= nxt;
            end
         end

         assign q = stg[LATENCY-1];

         AST_RESET_CLEARS: assert property (@(posedge clk)
            rst |=> !q)                                          // R7
            else $error("output not cleared after reset");

         AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (rst)
            !ce |=> $stable(q))                                  // R6
            else $error("output moved with enable low");

         AST_HEAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            ce |=> stg[0] == $past(d))                           // R5
            else $error("first stage missed the comparison result");
      end
   endgenerate

endmodule

// File: rtl/masked_eq_cmp.sv
module masked_eq_cmp
   import meq_pkg::*;
#(
   parameter int                     WIDTH      = 48,
   parameter int                     LATENCY    = 2,
   parameter meq_src_e               PAT_SRC    = SRC_BUS,
   parameter meq_src_e               MSK_SRC    = SRC_STATIC,
   parameter logic [MEQ_MAX_W-1:0]   STATIC_PAT = '0,
   parameter logic [MEQ_MAX_W-1:0]   STATIC_MSK = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic [WIDTH-1:0] data_in,
   input  logic [WIDTH-1:0] dyn_bus,
   output logic             match_q
);

   generate
      if (WIDTH < 1 || WIDTH > MEQ_MAX_W) begin : g_bad_width
         $error("masked_eq_cmp: WIDTH must lie in 1..48");
      end
      if (LATENCY < 0 || LATENCY > MEQ_MAX_LAT) begin : g_bad_latency
         $error("masked_eq_cmp: LATENCY must lie in 0..3");
      end
      if (PAT_SRC == SRC_BUS && MSK_SRC == SRC_BUS) begin : g_bad_sources
         $error("masked_eq_cmp: pattern and mask cannot both use the bus");
      end
   endgenerate

   logic [WIDTH-1:0] pat_w;
   logic [WIDTH-1:0] msk_w;
   logic             hit_w;

   meq_operand_sel #(
      .WIDTH      (WIDTH),
      .PAT_SRC    (PAT_SRC),
      .MSK_SRC    (MSK_SRC),
      .STATIC_PAT (STATIC_PAT),
      .STATIC_MSK (STATIC_MSK)
   ) u_sel (
      .dyn_bus (dyn_bus),
      .pat     (pat_w),
      .msk     (msk_w)
   );

   meq_match_core #(
      .WIDTH (WIDTH)
   ) u_core (
      .data (data_in),
      .pat  (pat_w),
      .msk  (msk_w),
      .hit  (hit_w)
   );

   meq_delay_line #(
      .LATENCY (LATENCY)
   ) u_dly (
      .clk (clk),
      .rst (rst),
      .ce  (ce),
      .d   (hit_w),
      .q   (match_q)
   );

endmodule

// File: tb/masked_eq_cmp_bench.sv
module masked_eq_cmp_bench;
   import meq_pkg::*;

   localparam logic [47:0] MAIN_MSK = 48'h0000_0000_00FF;
   localparam logic [47:0] L0_PAT   = 48'hFFFF_0000_A5C3;
   localparam logic [47:0] L1_PAT   = 48'hFFFF_FFFF_FF3C;
   localparam logic [47:0] L1_MSK   = 48'h0000_0000_000F;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce  = 1'b0;
   logic [47:0] data = '0;
   logic [47:0] bus  = '0;
   logic        q2, q0, q1, q3;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   // latency 2, bus = pattern, static mask on the low byte
   masked_eq_cmp #(.WIDTH(48), .LATENCY(2), .PAT_SRC(SRC_BUS), .MSK_SRC(SRC_STATIC),
                   .STATIC_PAT('0), .STATIC_MSK(MAIN_MSK)) u_masked_eq_cmp (
      .clk(clk), .rst(rst), .ce(ce), .data_in(data), .dyn_bus(bus), .match_q(q2));

   // latency 0, width 16, bus = mask, static pattern with noisy upper bits
   masked_eq_cmp #(.WIDTH(16), .LATENCY(0), .PAT_SRC(SRC_STATIC), .MSK_SRC(SRC_BUS),
                   .STATIC_PAT(L0_PAT), .STATIC_MSK('0)) u_lat0 (
      .clk(clk), .rst(rst), .ce(ce), .data_in(data[15:0]), .dyn_bus(bus[15:0]), .match_q(q0));

   // latency 1, width 8, both static
   masked_eq_cmp #(.WIDTH(8), .LATENCY(1), .PAT_SRC(SRC_STATIC), .MSK_SRC(SRC_STATIC),
                   .STATIC_PAT(L1_PAT), .STATIC_MSK(L1_MSK)) u_lat1 (
      .clk(clk), .rst(rst), .ce(ce), .data_in(data[7:0]), .dyn_bus(bus[7:0]), .match_q(q1));

   // latency 3, bus = pattern, nothing masked
   masked_eq_cmp #(.WIDTH(48), .LATENCY(3), .PAT_SRC(SRC_BUS), .MSK_SRC(SRC_STATIC),
                   .STATIC_PAT('0), .STATIC_MSK('0)) u_lat3 (
      .clk(clk), .rst(rst), .ce(ce), .data_in(data), .dyn_bus(bus), .match_q(q3));

   typedef struct {
      logic [3:0] exp;   // {l3, l1, l0, main}
      string      tag;
   } sb_item_t;

   sb_item_t sbq[$];

   // independent reference state
   logic [1:0] m2 = '0;
   logic       m1 = 1'b0;
   logic [2:0] m3 = '0;

   function automatic logic [47:0] rnd48();
      return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
   endfunction

   task automatic drive(input logic r, input logic e, input logic [47:0] dv,
                        input logic [47:0] bv, input string tag);
      logic c2, c0, c1, c3;
      sb_item_t it;
      @(negedge clk);
      rst  = r;
      ce   = e;
      data = dv;
      bus  = bv;
      c2 = (((dv ^ bv) & ~MAIN_MSK) == 48'h0);
      c0 = (((dv[15:0] ^ L0_PAT[15:0]) & ~bv[15:0]) == 16'h0);
      c1 = (((dv[7:0] ^ L1_PAT[7:0]) & ~L1_MSK[7:0]) == 8'h0);
      c3 = (dv == bv);
      @(posedge clk);
      if (r) begin
         m2 = '0; m1 = 1'b0; m3 = '0;
      end else if (e) begin
         m2 = {m2[0], c2};
         m1 = c1;
         m3 = {m3[1:0], c3};
      end
      it.exp = {m3[2], m1, c0, m2[1]};
      it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic cmp1(input logic act, input logic exp, input string tag, input string who);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b at %0t", tag, who, act, exp, $time);
      end
   endtask

   // monitor
   initial begin
      sb_item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            it = sbq.pop_front();
            cmp1(q2, it.exp[0], it.tag, "lat2");
            cmp1(q0, it.exp[1], it.tag, "lat0");
            cmp1(q1, it.exp[2], it.tag, "lat1");
            cmp1(q3, it.exp[3], it.tag, "lat3");
         end
      end
   end

   initial begin
      #(5 * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [47:0] v;
      logic [47:0] x;
      // R7 reset state, enable low
      for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, rnd48(), rnd48(), "R7");
      // R3 bus as pattern; R2 differences confined to masked low byte
      for (int i = 0; i < 12; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, v ^ {40'h0, 8'($urandom)}, v, "R2");
      end
      for (int i = 0; i < 8; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, v, v, "R3");
      end
      // R2 an unmasked single-bit difference must miss
      for (int i = 0; i < 8; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, v ^ (48'h100 << (i * 4)), v, "R2");
      end
      // R1 narrow copies: only low bits of data and pattern matter
      for (int i = 0; i < 10; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, {v[47:16], 16'hA5C3}, {v[47:8], 8'h00}, "R1");
      end
      for (int i = 0; i < 10; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, {v[47:8], 4'h3, v[3:0]}, rnd48(), "R1");
      end
      // R4 bus as mask: differences covered, then uncovered
      for (int i = 0; i < 10; i++) begin
         x = {32'h0, 16'($urandom)};
         v = rnd48();
         drive(1'b0, 1'b1, {v[47:16], 16'hA5C3 ^ x[15:0]}, x | {v[47:16], 16'h0}, "R4");
      end
      for (int i = 0; i < 6; i++) begin
         x = 48'h1 << i;
         drive(1'b0, 1'b1, {32'h0, 16'hA5C3 ^ x[15:0]}, ~x, "R4");
      end
      // R5 random traffic with enable high
      for (int i = 0; i < 40; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, ($urandom % 2) ? v : rnd48(), v, "R5");
      end
      // R6 enable toggling
      for (int i = 0; i < 40; i++) begin
         v = rnd48();
         drive(1'b0, 1'($urandom % 2), ($urandom % 2) ? v : rnd48(), v, "R6");
      end
      // R6 long stall after loading matches
      for (int i = 0; i < 4; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, {v[47:8], 8'h3C}, v, "R6");
      end
      for (int i = 0; i < 8; i++) drive(1'b0, 1'b0, rnd48(), rnd48(), "R6");
      // R7 reset with enable low while matches are in flight
      drive(1'b1, 1'b0, rnd48(), rnd48(), "R7");
      drive(1'b0, 1'b0, rnd48(), rnd48(), "R7");
      for (int i = 0; i < 6; i++) begin
         v = rnd48();
         drive(1'b0, 1'b1, v, v, "R5");
      end
      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule